// File: doc/BRIEF.md
# Truth Table Fitness Evaluator

This block grades a small population of candidate logic circuits against a target truth table and names the best one. Two internal tables share one address space: one holds the stimulus vector for each row and the other holds the outputs wanted for that row. Software fills both tables through a single write port. A start pulse launches a pass. The block walks the rows once for each candidate. It drives the stimulus vector out to the candidates, picks one candidate's outputs through a select multiplexer, and adds one point for every output bit that equals the wanted bit.

Candidates are scored in index order. A candidate's score is final after its last row. It replaces the running best only if it is strictly higher, so a tie keeps the lower index. With the default sizes of 3 inputs, 2 outputs and 8 rows, the maximum score is 16, which is a perfect match. The candidates themselves are outside this block: their outputs arrive as a flat combinational bus that depends on the driven vector.

Top module: `tt_fitness_eval`

## Requirements
- R1: After reset, busy and done are 0, best_idx is 0, best_score is 0 and vec_out is 0.
- R2: A candidate's score is the count of (row, output bit) pairs, over all ROWS rows, where its output bit equals the wanted bit. A match adds one and a mismatch adds nothing, so the default maximum is ROWS*N_OUT = 16.
- R3: A write with tbl_we high stores tbl_in_data and tbl_out_data at row tbl_addr. During a pass, row r's stored vector appears on vec_out, and the candidate outputs are compared against row r's wanted bits in the cycle that follows its issue. The third edge after the start edge shows row 2's vector.
- R4: best_idx and best_score report the highest score of the pass. On equal scores the lower index wins.
- R5: Candidate k's outputs are cand_outs[k*N_OUT +: N_OUT]. Candidates are scored in order from 0 to N_CAND-1.
- R6: done is a one-cycle pulse that rises N_CAND*ROWS+1 clock edges after the edge that samples start. best_idx and best_score are valid with done and stay unchanged until the next pass.
- R7: busy is high during a pass and is low in the cycle where done is high.
- R8: A start that arrives while busy is high is ignored. The pass timing does not change and no second pass follows.
- R9: A rewritten table row changes the scores of the next pass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launches a pass when idle |
| tbl_we | input | 1 | Table write enable |
| tbl_addr | input | AW (3) | Table row to write |
| tbl_in_data | input | N_IN (3) | Stimulus vector for the row |
| tbl_out_data | input | N_OUT (2) | Wanted outputs for the row |
| cand_outs | input | N_CAND*N_OUT (10) | Outputs of all candidates, candidate k at k*N_OUT |
| vec_out | output | N_IN (3) | Stimulus vector driven to the candidates |
| busy | output | 1 | Pass in progress |
| done | output | 1 | Pass finished, result valid |
| best_idx | output | CW (3) | Index of the winning candidate |
| best_score | output | SW (5) | Score of the winning candidate |

## Verification
The hardest cases to reach are a tie that involves the last-scored candidate and a winner that sits at the highest index. Both depend on how the whole population is arranged, not on any single row. The bench models each candidate as one of several fixed functions of vec_out with known scores. A vector table sets the population so that ties fall in the middle, an all-zero population occurs, and the perfect candidate sits last. A mid-pass start pulse and a rewrite of one table row then test the control path and the table path.

// File: rtl/ttf_pkg.sv
package ttf_pkg;
  typedef enum logic {SQ_IDLE, SQ_RUN} seq_state_e;
endpackage

// File: rtl/tt_table.sv
module tt_table #(
  parameter int DEPTH = 8,
  parameter int W     = 3,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/tt_sequencer.sv
module tt_sequencer
  import ttf_pkg::*;
#(
  parameter int ROWS   = 8,
  parameter int N_CAND = 5,
  parameter int N_IN   = 3,
  parameter int N_OUT  = 2,
  localparam int AW    = (ROWS > 1) ? $clog2(ROWS) : 1,
  localparam int CW    = (N_CAND > 1) ? $clog2(N_CAND) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [N_IN-1:0]  rd_vec,
  input  logic [N_OUT-1:0] rd_exp,
  output logic [AW-1:0]    rd_addr,
  output logic [N_IN-1:0]  vec_q,
  output logic [N_OUT-1:0] exp_q,
  output logic [CW-1:0]    sel_q,
  output logic             valid_q,
  output logic             first_q,
  output logic             last_row_q,
  output logic             last_cand_q,
  output logic             busy
);
  seq_state_e    state;
  logic [AW-1:0] row_q;
  logic [CW-1:0] cand_q;

  logic running, launch, row_end, cand_end;
  assign running  = (state == SQ_RUN);
  assign busy     = running | valid_q;
  assign launch   = start & ~busy;
  assign row_end  = (row_q == AW'(ROWS - 1));
  assign cand_end = (cand_q == CW'(N_CAND - 1));
  assign rd_addr  = row_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state       <= SQ_IDLE;
      row_q       <= '0;
      cand_q      <= '0;
      vec_q       <= '0;
      exp_q       <= '0;
      sel_q       <= '0;
      valid_q     <= 1'b0;
      first_q     <= 1'b0;
      last_row_q  <= 1'b0;
      last_cand_q <= 1'b0;
    end else begin
      valid_q <= running;
      if (running) begin
        vec_q       <= rd_vec;
        exp_q       <= rd_exp;
        sel_q       <= cand_q;
        first_q     <= (row_q == '0);
        last_row_q  <= row_end;
        last_cand_q <= cand_end;
      end
      case (state)
        SQ_IDLE: if (launch) begin
          state  <= SQ_RUN;
          row_q  <= '0;
          cand_q <= '0;
        end
        SQ_RUN: begin
          if (row_end) begin
            row_q <= '0;
            if (cand_end) state <= SQ_IDLE;
            else          cand_q <= cand_q + 1'b1;
          end else begin
            row_q <= row_q + 1'b1;
          end
        end
        default: state <= SQ_IDLE;
      endcase
    end
  end

  // R5
  sel_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |-> (sel_q < CW'(N_CAND)));

  // R8
  start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (running && start && !row_end) |=> (row_q == $past(row_q) + 1'b1));
endmodule

// File: rtl/tt_scorer.sv
module tt_scorer #(
  parameter int ROWS   = 8,
  parameter int N_CAND = 5,
  parameter int N_OUT  = 2,
  localparam int CW    = (N_CAND > 1) ? $clog2(N_CAND) : 1,
  localparam int MAXS  = ROWS * N_OUT,
  localparam int SW    = $clog2(MAXS + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [N_CAND*N_OUT-1:0] cand_outs,
  input  logic [N_OUT-1:0]        exp_q,
  input  logic [CW-1:0]           sel_q,
  input  logic                    valid_q,
  input  logic                    first_q,
  input  logic                    last_row_q,
  input  logic                    last_cand_q,
  output logic                    done,
  output logic [CW-1:0]           best_idx,
  output logic [SW-1:0]           best_score
);
  function automatic logic [SW-1:0] count_eq(input logic [N_OUT-1:0] got,
                                              input logic [N_OUT-1:0] want);
    logic [SW-1:0] n;
    n = '0;
    for (int i = 0; i < N_OUT; i++)
      n = n + {{(SW-1){1'b0}}, ~(got[i] ^ want[i])};
    return n;
  endfunction

  logic [N_OUT-1:0] slice [N_CAND];
  for (genvar g = 0; g < N_CAND; g++) begin : g_slice
    assign slice[g] = cand_outs[g*N_OUT +: N_OUT];
  end

  logic [N_OUT-1:0] pick;
  always_comb begin
    pick = '0;
    for (int k = 0; k < N_CAND; k++)
      if (sel_q == CW'(k)) pick = slice[k];
  end

  logic [SW-1:0] acc_q, sum_nxt;
  logic          cand_fin, better;
  assign sum_nxt  = (first_q ? '0 : acc_q) + count_eq(pick, exp_q);
  assign cand_fin = valid_q & last_row_q;
  assign better   = (sel_q == '0) | (sum_nxt > best_score);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q      <= '0;
      best_idx   <= '0;
      best_score <= '0;
      done       <= 1'b0;
    end else begin
      if (valid_q) acc_q <= sum_nxt;
      if (cand_fin && better) begin
        best_idx   <= sel_q;
        best_score <= sum_nxt;
      end
      done <= cand_fin & last_cand_q;
    end
  end

  // R2
  acc_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |-> (sum_nxt <= SW'(MAXS)));

  // R4
  best_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cand_fin && sel_q != '0) |=> (best_score >= $past(best_score)));

  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

// File: rtl/tt_fitness_eval.sv
module tt_fitness_eval #(
  parameter int N_IN   = 3,
  parameter int N_OUT  = 2,
  parameter int ROWS   = 8,
  parameter int N_CAND = 5,
  localparam int AW    = (ROWS > 1) ? $clog2(ROWS) : 1,
  localparam int CW    = (N_CAND > 1) ? $clog2(N_CAND) : 1,
  localparam int SW    = $clog2(ROWS * N_OUT + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic                    tbl_we,
  input  logic [AW-1:0]           tbl_addr,
  input  logic [N_IN-1:0]         tbl_in_data,
  input  logic [N_OUT-1:0]        tbl_out_data,
  input  logic [N_CAND*N_OUT-1:0] cand_outs,
  output logic [N_IN-1:0]         vec_out,
  output logic                    busy,
  output logic                    done,
  output logic [CW-1:0]           best_idx,
  output logic [SW-1:0]           best_score
);
  logic [AW-1:0]    rd_addr;
  logic [N_IN-1:0]  rd_vec;
  logic [N_OUT-1:0] rd_exp, exp_q;
  logic [CW-1:0]    sel_q;
  logic             valid_q, first_q, last_row_q, last_cand_q;

  tt_table #(.DEPTH(ROWS), .W(N_IN)) u_in_tbl (
    .clk(clk), .we(tbl_we), .waddr(tbl_addr), .wdata(tbl_in_data),
    .raddr(rd_addr), .rdata(rd_vec));

  tt_table #(.DEPTH(ROWS), .W(N_OUT)) u_out_tbl (
    .clk(clk), .we(tbl_we), .waddr(tbl_addr), .wdata(tbl_out_data),
    .raddr(rd_addr), .rdata(rd_exp));

  tt_sequencer #(.ROWS(ROWS), .N_CAND(N_CAND), .N_IN(N_IN), .N_OUT(N_OUT)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .rd_vec(rd_vec), .rd_exp(rd_exp),
    .rd_addr(rd_addr), .vec_q(vec_out), .exp_q(exp_q), .sel_q(sel_q),
    .valid_q(valid_q), .first_q(first_q), .last_row_q(last_row_q),
    .last_cand_q(last_cand_q), .busy(busy));

  tt_scorer #(.ROWS(ROWS), .N_CAND(N_CAND), .N_OUT(N_OUT)) u_score (
    .clk(clk), .rst_n(rst_n), .cand_outs(cand_outs), .exp_q(exp_q),
    .sel_q(sel_q), .valid_q(valid_q), .first_q(first_q),
    .last_row_q(last_row_q), .last_cand_q(last_cand_q),
    .done(done), .best_idx(best_idx), .best_score(best_score));

  // R7
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R6
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && $past(!busy)) |-> $stable(best_score));
endmodule

// File: tb/sim_tt_fitness_eval.sv
module sim_tt_fitness_eval;
  localparam int N_CASES = 5;
  localparam int LAT     = 5 * 8 + 1;
  // candidate kinds packed 3 bits each, candidate k at [k*3 +: 3]
  localparam logic [14:0] CASE_KINDS [N_CASES] = '{
    {3'd4, 3'd3, 3'd2, 3'd1, 3'd0},
    {3'd5, 3'd4, 3'd2, 3'd3, 3'd1},
    {3'd2, 3'd2, 3'd2, 3'd2, 3'd2},
    {3'd0, 3'd1, 3'd5, 3'd4, 3'd2},
    {3'd3, 3'd5, 3'd3, 3'd2, 3'd4}};
  localparam int EXP_IDX [N_CASES] = '{0, 0, 0, 4, 2};
  localparam int EXP_SC  [N_CASES] = '{16, 12, 0, 16, 12};

  logic clk = 0, rst_n = 0, start = 0, tbl_we = 0;
  logic [2:0] tbl_addr = '0, tbl_in_data = '0, vec_out;
  logic [1:0] tbl_out_data = '0;
  logic [9:0] cand_outs;
  logic busy, done;
  logic [2:0] best_idx;
  logic [4:0] best_score;
  logic [2:0] kinds [5];
  logic [1:0] want [8];
  int n_chk = 0, n_bad = 0;

  always #2 clk = ~clk;

  tt_fitness_eval u0 (.*);

  function automatic logic [1:0] target(input logic [2:0] v);
    return v[2] ? v[1:0] : 2'b00;
  endfunction

  function automatic logic [1:0] cand_fn(input logic [2:0] k, input logic [2:0] v);
    case (k)
      3'd0: return target(v);
      3'd1: return 2'b00;
      3'd2: return ~target(v);
      3'd3: return v[1:0];
      3'd4: return 2'b11;
      default: return target(v) ^ 2'b10;
    endcase
  endfunction

  always_comb
    for (int k = 0; k < 5; k++) cand_outs[k*2 +: 2] = cand_fn(kinds[k], vec_out);

  function automatic int model_score(input logic [2:0] k);
    int s = 0;
    for (int r = 0; r < 8; r++) begin
      logic [1:0] o = cand_fn(k, 3'(r));
      for (int b = 0; b < 2; b++) if (o[b] == want[r][b]) s++;
    end
    return s;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr_row(input int r, input logic [1:0] o);
    @(negedge clk);
    tbl_we = 1; tbl_addr = 3'(r); tbl_in_data = 3'(r); tbl_out_data = o;
    want[r] = o;
    @(negedge clk);
    tbl_we = 0;
  endtask

  task automatic run_pass(input bit poke, output int lat);
    @(negedge clk);
    start = 1;
    @(posedge clk); #1;
    start = 0;
    lat = 0;
    while (!done && lat < 200) begin
      @(posedge clk); #1;
      lat++;
      if (lat == 3) chk("R3 vec_out row2", int'(vec_out), 2);
      if (lat == 5) chk("R7 busy mid-pass", int'(busy), 1);
      if (poke && lat == 10) start = 1;
      if (poke && lat == 11) start = 0;
    end
  endtask

  task automatic after_done(input string req, input int idx, input int sc);
    repeat (3) @(posedge clk);
    #1;
    chk({req, " done low after"}, int'(done), 0);
    chk({req, " busy low after"}, int'(busy), 0);
    chk({req, " idx held"}, int'(best_idx), idx);
    chk({req, " score held"}, int'(best_score), sc);
  endtask

  initial begin
    #(200000 * 4);
    n_bad++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk + 1, n_bad);
    $finish;
  end

  initial begin
    int lat, bi, bs, s;
    for (int k = 0; k < 5; k++) kinds[k] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    #1;
    // R1
    chk("R1 busy", int'(busy), 0);
    chk("R1 done", int'(done), 0);
    chk("R1 best_idx", int'(best_idx), 0);
    chk("R1 best_score", int'(best_score), 0);
    chk("R1 vec_out", int'(vec_out), 0);

    for (int r = 0; r < 8; r++) wr_row(r, target(3'(r)));

    for (int c = 0; c < N_CASES; c++) begin
      for (int k = 0; k < 5; k++) kinds[k] = CASE_KINDS[c][k*3 +: 3];
      run_pass(c == 1, lat);
      chk("R6 done latency", lat, LAT);
      chk("R4 R5 best_idx", int'(best_idx), EXP_IDX[c]);
      chk("R2 best_score", int'(best_score), EXP_SC[c]);
      after_done(c == 1 ? "R8" : "R6", EXP_IDX[c], EXP_SC[c]);
    end

    // R9: rewrite row 0 wanted bits, rescore population of case 0
    wr_row(0, 2'b11);
    for (int k = 0; k < 5; k++) kinds[k] = CASE_KINDS[0][k*3 +: 3];
    bi = 0; bs = -1;
    for (int k = 0; k < 5; k++) begin
      s = model_score(kinds[k]);
      if (s > bs) begin bs = s; bi = k; end
    end
    chk("R9 model sanity", bs, 14);
    run_pass(1'b0, lat);
    chk("R9 best_idx", int'(best_idx), bi);
    chk("R9 best_score", int'(best_score), bs);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule